// File: doc/BRIEF.md
# BCD Real-Time Calendar with Two-Stage Prescaler

This block keeps the time of day and the calendar date in packed BCD. A slow-clock enable input (`rtc_en`, one pulse per cycle of the real-time reference) drives a two-stage divider. A first counter of programmable length feeds a second counter of programmable length, and the second stage's wrap produces one seconds tick. Each tick advances seconds, minutes, hours, day, weekday, month and two-digit year with full BCD carry, month lengths and leap years.

Software reaches the block through a small word-addressed register bus with four registers. The time, date and divider settings are writable only inside an initialization window. Software asks for the window with a request bit. The block grants it by setting an acknowledge bit a fixed number of slow-clock enables later, and it keeps the divider and calendar stopped while the acknowledge is set. Reads of time and date return copies that are refreshed on every slow-clock enable outside the window. A synchronization flag tells software when those copies are fresh again after it cleared the flag or left the window.

Top module: `bcd_rtc_core`

## Requirements
- R1: After synchronous reset, the time (address 0) and date (address 1) words read 0. The control word (address 2) reads 0. The divider word (address 3) reads 0x007F7FFF, which holds both stages at their maximum.
- R2: Writing control bit 0 = 1 sets the request. Acknowledge (control bit 1) rises on the second slow-clock enable seen while the request is set. It falls one clock after the request is cleared.
- R3: Writes to time, date and divider change nothing unless the acknowledge is set. Time packs seconds in bits 6:0, minutes in 14:8 and hours in 21:16. Date packs day in 5:0, month in 12:8, weekday in 15:13 and year in 23:16. The divider word has stage one in bits 22:16 and stage two in bits 14:0. Bits outside these fields are dropped.
- R4: With stage settings A and B, a seconds tick occurs every (A+1)*(B+1) slow-clock enables. Both stages restart from zero whenever the acknowledge is set.
- R5: Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and carry into the date.
- R6: The day wraps to 01 after the month's last day. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Each day advance steps the weekday (1 = Monday … 7 = Sunday), with 7 wrapping to 1.
- R8: While the acknowledge is set, enables neither advance the calendar nor produce a tick.
- R9: The sync flag (control bit 2) is cleared by a control write with bit 2 = 0 and while the request or acknowledge is set. A write with bit 2 = 1 leaves it as it is. Otherwise it is set on the second enable outside the window. Time and date reads return copies updated on every enable outside the window.
- R10: Control bit 3 reads 1 exactly when the live year field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous reset, active high |
| rtc_en | input | 1 | One-cycle enable per slow reference clock cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 time, 1 date, 2 control, 3 divider |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sec_tick | output | 1 | One-cycle seconds tick from the divider |

## Verification
Directed starting points sit on every carry boundary: end of minute and end of hour, February in leap and common years, 30- and 31-day months, and year 99 at the end of December with weekday 7. Each one separates a different branch of the carry chain. Random valid start dates with random short divider settings are then advanced by random tick counts, which mixes multi-level carries with divider periods of 1 to 9 enables. The window is probed enable by enable to pin down the acknowledge and sync latencies. The probes also show that the calendar stays frozen inside the window and that writes outside it are dropped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [2:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a BCD month; year divisible by 4 iff (2*tens + ones) mod 4 == 0
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [1:0] r;
    r = {yr[4], 1'b0} + yr[1:0];
    case (mon)
      8'h02:                      return (r == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // One second forward with full carry chain
  function automatic cal_t cal_next(input cal_t c);
    cal_t n;
    n = c;
    if (c.sec < 8'h59) n.sec = bcd_inc(c.sec);
    else begin
      n.sec = 8'h00;
      if (c.min < 8'h59) n.min = bcd_inc(c.min);
      else begin
        n.min = 8'h00;
        if (c.hour < 8'h23) n.hour = bcd_inc(c.hour);
        else begin
          n.hour = 8'h00;
          n.wday = (c.wday == 3'd7) ? 3'd1 : c.wday + 3'd1;
          if (c.day < month_len(c.mon, c.year)) n.day = bcd_inc(c.day);
          else begin
            n.day = 8'h01;
            if (c.mon < 8'h12) n.mon = bcd_inc(c.mon);
            else begin
              n.mon  = 8'h01;
              n.year = (c.year >= 8'h99) ? 8'h00 : bcd_inc(c.year);
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [31:0] pack_time(input cal_t c);
    return {10'd0, c.hour[5:0], 1'b0, c.min[6:0], 1'b0, c.sec[6:0]};
  endfunction

  function automatic logic [31:0] pack_date(input cal_t c);
    return {8'd0, c.year, c.wday, c.mon[4:0], 2'b0, c.day[5:0]};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           hold,
  input  logic [A_W-1:0] div_a,
  input  logic [S_W-1:0] div_s,
  output logic           tick
);
  logic [A_W-1:0] cnt_a;
  logic [S_W-1:0] cnt_s;
  logic           a_wrap;

  assign a_wrap = (cnt_a == div_a);
  assign tick   = en && !hold && a_wrap && (cnt_s == div_s);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_a <= '0;
      cnt_s <= '0;
    end else if (en) begin
      if (a_wrap) begin
        cnt_a <= '0;
        if (cnt_s == div_s) cnt_s <= '0;
        else                cnt_s <= cnt_s + 1'b1;
      end else begin
        cnt_a <= cnt_a + 1'b1;
      end
    end
  end

  // R4: a period longer than one enable never yields back-to-back ticks
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && (div_a != '0 || div_s != '0)) |=> !tick);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        ld_time,
  input  logic        ld_date,
  input  logic [31:0] wdata,
  output cal_t        cal_q,
  output cal_t        cal_nxt
);

  always_comb begin
    cal_nxt = cal_q;
    if (ld_time) begin
      cal_nxt.sec  = {1'b0, wdata[6:0]};
      cal_nxt.min  = {1'b0, wdata[14:8]};
      cal_nxt.hour = {2'b0, wdata[21:16]};
    end else if (ld_date) begin
      cal_nxt.day  = {2'b0, wdata[5:0]};
      cal_nxt.mon  = {3'b0, wdata[12:8]};
      cal_nxt.wday = wdata[15:13];
      cal_nxt.year = wdata[23:16];
    end else if (tick) begin
      cal_nxt = cal_next(cal_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cal_q <= '0;
    else     cal_q <= cal_nxt;
  end

  logic quiet, at_midnight;
  assign quiet       = !ld_time && !ld_date;
  assign at_midnight = (cal_q.hour == 8'h23) && (cal_q.min == 8'h59) && (cal_q.sec == 8'h59);

  // R5: seconds wrap on a tick at 59
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && quiet && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00));

  // R7: Sunday rolls over to Monday at midnight
  a_r7_wday_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && quiet && at_midnight && cal_q.wday == 3'd7) |=> (cal_q.wday == 3'd1));

  // R6: end of December starts January
  a_r6_year_end: assert property (@(posedge clk) disable iff (rst)
    (tick && quiet && at_midnight && cal_q.mon == 8'h12 && cal_q.day == 8'h31) |=> (cal_q.mon == 8'h01));

  // R8: without tick or load the calendar holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && quiet) |=> $stable(cal_q));

endmodule

// File: rtl/rtc_sync_ctrl.sv
module rtc_sync_ctrl #(
  parameter int SYNC_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ctrl_wr,
  input  logic wr_req,
  input  logic wr_sync,
  output logic init_req,
  output logic init_ack,
  output logic sync_ok
);
  localparam int CNT_W = $clog2(SYNC_LAT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_LAT - 1);

  logic [CNT_W-1:0] ack_cnt, syn_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_req <= 1'b0;
      init_ack <= 1'b0;
      sync_ok  <= 1'b0;
      ack_cnt  <= '0;
      syn_cnt  <= '0;
    end else begin
      if (ctrl_wr) init_req <= wr_req;

      if (!init_req) begin
        init_ack <= 1'b0;
        ack_cnt  <= '0;
      end else if (!init_ack && en) begin
        if (ack_cnt == LAST) begin
          init_ack <= 1'b1;
          ack_cnt  <= '0;
        end else begin
          ack_cnt <= ack_cnt + 1'b1;
        end
      end

      if (init_req || init_ack || (ctrl_wr && !wr_sync)) begin
        sync_ok <= 1'b0;
        syn_cnt <= '0;
      end else if (!sync_ok && en) begin
        if (syn_cnt == LAST) begin
          sync_ok <= 1'b1;
          syn_cnt <= '0;
        end else begin
          syn_cnt <= syn_cnt + 1'b1;
        end
      end
    end
  end

  // R2: acknowledge only rises under a standing request
  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(init_ack) |-> init_req);

  // R2: acknowledge drops one clock after the request goes away
  a_r2_ack_drops: assert property (@(posedge clk) disable iff (rst)
    !init_req |=> !init_ack);

  // R9: flag is low after any cycle inside the window
  a_r9_sync_low_in_init: assert property (@(posedge clk) disable iff (rst)
    (init_req || init_ack) |=> !sync_ok);

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int A_W      = 7,
  parameter int S_W      = 15,
  parameter int SYNC_LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rtc_en,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sec_tick
);
  localparam logic [1:0] ADR_TIME = 2'd0;
  localparam logic [1:0] ADR_DATE = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;
  localparam logic [1:0] ADR_DIV  = 2'd3;
  localparam int A_LSB = 16;

  logic init_req, init_ack, sync_ok, cal_valid;
  logic ld_time, ld_date, ld_div, ctrl_wr;
  logic [A_W-1:0] div_a;
  logic [S_W-1:0] div_s;
  cal_t cal_q, cal_nxt;
  logic [31:0] shd_time, shd_date;

  assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
  assign ld_time = bus_wr && init_ack && (bus_addr == ADR_TIME);
  assign ld_date = bus_wr && init_ack && (bus_addr == ADR_DATE);
  assign ld_div  = bus_wr && init_ack && (bus_addr == ADR_DIV);

  rtc_sync_ctrl #(.SYNC_LAT(SYNC_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .en(rtc_en), .ctrl_wr(ctrl_wr),
    .wr_req(bus_wdata[0]), .wr_sync(bus_wdata[2]),
    .init_req(init_req), .init_ack(init_ack), .sync_ok(sync_ok)
  );

  rtc_prescaler #(.A_W(A_W), .S_W(S_W)) u_div (
    .clk(clk), .rst(rst), .en(rtc_en), .hold(init_ack),
    .div_a(div_a), .div_s(div_s), .tick(sec_tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .tick(sec_tick), .ld_time(ld_time), .ld_date(ld_date),
    .wdata(bus_wdata), .cal_q(cal_q), .cal_nxt(cal_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_a <= '1;
      div_s <= '1;
    end else if (ld_div) begin
      div_a <= bus_wdata[A_LSB +: A_W];
      div_s <= bus_wdata[0 +: S_W];
    end
  end

  // Read copies follow the live counters on each enable outside the window
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_time <= '0;
      shd_date <= '0;
    end else if (rtc_en && !init_ack) begin
      shd_time <= pack_time(cal_nxt);
      shd_date <= pack_date(cal_nxt);
    end
  end

  assign cal_valid = (cal_q.year != 8'h00);

  always_comb begin
    case (bus_addr)
      ADR_TIME: bus_rdata = shd_time;
      ADR_DATE: bus_rdata = shd_date;
      ADR_CTRL: bus_rdata = {28'd0, cal_valid, sync_ok, init_ack, init_req};
      default:  bus_rdata = (32'(div_a) << A_LSB) | 32'(div_s);
    endcase
  end

  // R8: no seconds tick inside the window
  a_r8_no_tick_in_init: assert property (@(posedge clk) disable iff (rst)
    init_ack |-> !sec_tick);

  // R3: divider write outside the window leaves the settings alone
  a_r3_div_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_DIV && !init_ack) |=> ($stable(div_a) && $stable(div_s)));

endmodule

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rtc_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sec_tick;

  int checks = 0;
  int errs = 0;
  int mh, mm, ms, md, mmo, my, mw;

  bcd_rtc_core u0 (
    .clk(clk), .rst(rst), .rtc_en(rtc_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_tick(sec_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int days_of(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] exp_time();
    return 32'((bcd(mh) << 16) | (bcd(mm) << 8) | bcd(ms));
  endfunction

  function automatic logic [31:0] exp_date();
    return 32'((bcd(my) << 16) | (mw << 13) | (bcd(mmo) << 8) | bcd(md));
  endfunction

  // Binary model of one second, counted in plain integers
  task automatic model_step(input int n);
    for (int i = 0; i < n; i++) begin
      int t;
      t = ms + 60 * mm + 3600 * mh + 1;
      if (t == 86400) begin
        t = 0;
        mw = (mw == 7) ? 1 : mw + 1;
        if (md == days_of(mmo, my)) begin
          md = 1;
          if (mmo == 12) begin mmo = 1; my = (my + 1) % 100; end
          else mmo = mmo + 1;
        end else md = md + 1;
      end
      mh = t / 3600; mm = (t / 60) % 60; ms = t % 60;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_en(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rtc_en = 1'b1;
    end
    @(negedge clk);
    rtc_en = 1'b0;
  endtask

  task automatic load(input int a, input int s, input int h, input int m, input int sc,
                      input int d, input int mo, input int y, input int w);
    mh = h; mm = m; ms = sc; md = d; mmo = mo; my = y; mw = w;
    wr(2'd2, 32'h1);
    run_en(2);
    wr(2'd3, 32'((a << 16) | s));
    wr(2'd0, exp_time());
    wr(2'd1, exp_date());
    wr(2'd2, 32'h0);
  endtask

  task automatic cmp_cal(input string req);
    logic [31:0] v;
    rd(2'd0, v); chk({req, " time"}, v, exp_time());
    rd(2'd1, v); chk({req, " date"}, v, exp_date());
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(2'd0, v); chk("R1 time", v, 32'h0);
    rd(2'd1, v); chk("R1 date", v, 32'h0);
    rd(2'd2, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd3, v); chk("R1 divider", v, 32'h007F7FFF);

    // R2: acknowledge latency and release
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk("R2 req no ack", v & 32'h3, 32'h1);
    run_en(1);
    rd(2'd2, v); chk("R2 ack after 1 enable", v & 32'h2, 32'h0);
    run_en(1);
    rd(2'd2, v); chk("R2 ack after 2 enables", v & 32'h2, 32'h2);
    chk("R9 sync low in window", v & 32'h4, 32'h0);
    wr(2'd3, 32'h0002_0003);
    mh = 10; mm = 20; ms = 30; md = 15; mmo = 6; my = 0; mw = 2;
    wr(2'd0, exp_time() | 32'hFF80_8080);
    wr(2'd1, exp_date() | 32'hFF00_00C0);
    rd(2'd2, v); chk("R10 year zero", v & 32'h8, 32'h0);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R2 ack released", v & 32'h3, 32'h0);

    // R9: sync flag timing
    run_en(1);
    rd(2'd2, v); chk("R9 sync after 1 enable", v & 32'h4, 32'h0);
    run_en(1);
    rd(2'd2, v); chk("R9 sync after 2 enables", v & 32'h4, 32'h4);
    // R3: field masking of in-window writes
    cmp_cal("R3 masked load");

    // R4: divider A=2,S=3 gives 12 enables per second
    run_en(9);
    cmp_cal("R4 before period");
    run_en(1); model_step(1);
    cmp_cal("R4 at period");
    wr(2'd2, 32'h4);
    rd(2'd2, v); chk("R9 write one keeps", v & 32'h4, 32'h4);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R9 write zero clears", v & 32'h4, 32'h0);
    run_en(2);
    rd(2'd2, v); chk("R9 set again", v & 32'h4, 32'h4);
    run_en(10); model_step(1);
    cmp_cal("R4 second period");

    // R3: writes outside the window are dropped
    wr(2'd0, 32'h0012_3456);
    wr(2'd1, 32'h0099_2131);
    wr(2'd3, 32'h0);
    run_en(1);
    cmp_cal("R3 ignored writes");
    rd(2'd3, v); chk("R3 divider kept", v, 32'h0002_0003);

    // R8: frozen inside the window (A=0,S=0: one tick per enable)
    load(0, 0, 5, 6, 7, 9, 9, 9, 3);
    run_en(2); model_step(2);
    cmp_cal("R8 baseline");
    wr(2'd2, 32'h1);
    run_en(2); model_step(2);
    run_en(5);
    wr(2'd2, 32'h0);
    run_en(2); model_step(2);
    cmp_cal("R8 frozen window");
    rd(2'd2, v); chk("R10 year nonzero", v & 32'h8, 32'h8);

    // R5: carries
    load(0, 0, 0, 0, 59, 1, 1, 30, 1);
    run_en(1); model_step(1); cmp_cal("R5 minute carry");
    load(0, 0, 12, 59, 59, 1, 1, 30, 1);
    run_en(1); model_step(1); cmp_cal("R5 hour carry");
    // R6, R7: date carries
    load(0, 0, 23, 59, 59, 28, 2, 24, 3);
    run_en(1); model_step(1); cmp_cal("R6 leap Feb 28");
    load(0, 0, 23, 59, 59, 29, 2, 24, 4);
    run_en(1); model_step(1); cmp_cal("R6 leap Feb 29");
    load(0, 0, 23, 59, 59, 28, 2, 23, 2);
    run_en(1); model_step(1); cmp_cal("R6 common Feb 28");
    load(0, 0, 23, 59, 59, 30, 4, 41, 6);
    run_en(1); model_step(1); cmp_cal("R6 April end");
    load(0, 0, 23, 59, 59, 31, 12, 99, 7);
    run_en(1); model_step(1); cmp_cal("R7 R6 year wrap Sunday");
    rd(2'd2, v); chk("R10 year wrapped to zero", v & 32'h8, 32'h0);

    // R5 R6 R7: random starts, dividers and run lengths
    for (int it = 0; it < 10; it++) begin
      int a, s, k, y, mo;
      a = $urandom % 3; s = $urandom % 3; k = 2 + $urandom % 150;
      y = $urandom % 100; mo = 1 + $urandom % 12;
      load(a, s, $urandom % 24, $urandom % 60, $urandom % 60,
           1 + $urandom % days_of(mo, y), mo, y, 1 + $urandom % 7);
      run_en(k * (a + 1) * (s + 1));
      model_step(k);
      cmp_cal("R5 R6 R7 random");
    end

    finish_run();
  end
endmodule